// File: doc/BRIEF.md
# SPI Flash Command Engine

The block is a register-mapped SPI host that runs a single flash command at a time. Software places an opcode in its own register, sets how many bytes follow the opcode and how many are to be read back, and writes the outgoing bytes into a 71-byte buffer. A write with the start bit set runs the command. The engine drops chip select, shifts out the opcode and then the buffered bytes in SPI mode 0 on one data lane, and then clocks in the requested reply bytes. Replies are written into the same buffer, starting at the slot just after the last byte sent. The status busy bit stays high for the whole frame.

A list of four opcode slots, each with its own enable bit, guards the engine. If the loaded opcode matches an enabled slot when the start bit is written, no frame is sent. A sticky illegal-access flag is raised instead, and software clears it by writing a one to it. The SPI clock is the system clock divided by a programmable half-period, so one half-period lasts D+1 system cycles, where D is the divider value.

The sequencer has four states. IDLE goes to SETUP on an accepted start, and chip select falls. SETUP goes to SHIFT when its half-period ends, and SCK rises for the first time. SHIFT toggles SCK once per half-period and goes to HOLD on the falling edge after the last bit. HOLD goes back to IDLE after one more half-period, and chip select rises.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, cs_n is high, SCK is low, the busy bit reads 0, the illegal flag reads 0 and the divider (address 0x09) reads 1.
- R2: Byte registers read back what was written: opcode at 0x45, send count at 0x48, receive count at 0x4B, divider at 0x09, blocked opcodes at 0x04 to 0x07, slot enables in bits 3:0 of 0x08, buffer slot i at 0x80+i for i from 0 to 70.
- R3: Writing a byte with bit 7 set to address 0x47 starts a frame. The busy bit (bit 7 of 0x4F, bit 31 of the status word) is 1 from the cycle after that write, for exactly (16N+1)(D+1) cycles, where N = 1 + send count + receive count.
- R4: cs_n is low exactly while a frame is in progress, and SCK is low whenever cs_n is high. The first SCK rise comes D+1 cycles after cs_n falls. MOSI changes only on a falling SCK edge or when cs_n falls.
- R5: MOSI carries, most significant bit first, the opcode, then buffer slots 0 to send count - 1, then 0x00 for each byte received.
- R6: Received byte k, sampled on rising SCK edges MSB first, is stored in buffer slot send count + k. No other buffer slot changes.
- R7: A send count above 71 is used as 71, and the receive count is limited to 71 minus the send count in use.
- R8: If the opcode equals a blocked slot whose enable bit is set, a start sets the illegal flag (bit 5 of 0x02, bit 21 of the control word). cs_n does not fall and busy stays 0.
- R9: The illegal flag stays set when 0 is written to bit 5 of 0x02 and clears when 1 is written there. An opcode whose matching slot is disabled runs normally.
- R10: A start written while busy is ignored. The frame in progress ends at its normal time and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions rely on a few input conditions. Software does not write the counts, the opcode or the buffer while a frame runs. The divider is constant during a frame. MISO settles before the next rising SCK edge. Under these conditions the buffer writes from the engine land only inside the 71-byte range and only while chip select is low. The stimulus follows these rules. All configuration is written while idle, and the only write made during a frame is a repeated start. A bench device model changes MISO right after each falling SCK edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } eng_state_t;

    localparam logic [7:0] ADR_CTRL2  = 8'h02;
    localparam logic [7:0] ADR_BLK0   = 8'h04;
    localparam logic [7:0] ADR_BLK_EN = 8'h08;
    localparam logic [7:0] ADR_DIV    = 8'h09;
    localparam logic [7:0] ADR_OPC    = 8'h45;
    localparam logic [7:0] ADR_GO     = 8'h47;
    localparam logic [7:0] ADR_TXN    = 8'h48;
    localparam logic [7:0] ADR_RXN    = 8'h4B;
    localparam logic [7:0] ADR_STAT   = 8'h4F;
    localparam logic [7:0] ADR_BUF    = 8'h80;

endpackage

// File: rtl/spi_cmd_block.sv
module spi_cmd_block #(
    parameter int SLOTS = 4
) (
    input  logic [7:0]            opcode,
    input  logic [SLOTS-1:0][7:0] blk_op,
    input  logic [SLOTS-1:0]      blk_en,
    output logic                  hit
);

    logic [SLOTS-1:0] match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign match[g] = blk_en[g] && (blk_op[g] == opcode);
    end

    assign hit = |match;

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int         BUF_BYTES = 71,
    parameter int         SLOTS     = 4,
    parameter logic [7:0] DIV_RESET = 8'd1,
    localparam int        BIDX_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            reg_addr,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  busy,
    input  logic                  illegal_set,
    input  logic [BIDX_W-1:0]     eng_rd_idx,
    output logic [7:0]            eng_rd_data,
    input  logic                  eng_wr_en,
    input  logic [BIDX_W-1:0]     eng_wr_idx,
    input  logic [7:0]            eng_wr_data,
    output logic [7:0]            opcode,
    output logic [7:0]            tx_cnt,
    output logic [7:0]            rx_cnt,
    output logic [7:0]            div,
    output logic [SLOTS-1:0][7:0] blk_op,
    output logic [SLOTS-1:0]      blk_en,
    output logic                  illegal,
    output logic                  trig
);

    localparam logic [7:0]        BUF_LEN8 = 8'(BUF_BYTES);
    localparam logic [BIDX_W-1:0] BUF_LENI = BIDX_W'(BUF_BYTES);

    logic [7:0]        mem [BUF_BYTES];
    logic [7:0]        buf_off;
    logic [BIDX_W-1:0] bus_idx;
    logic              buf_hit;

    assign buf_off = reg_addr - ADR_BUF;
    assign bus_idx = buf_off[BIDX_W-1:0];
    assign buf_hit = (reg_addr >= ADR_BUF) && (buf_off < BUF_LEN8);
    assign trig    = reg_wr && (reg_addr == ADR_GO) && reg_wdata[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode  <= '0;
            tx_cnt  <= '0;
            rx_cnt  <= '0;
            div     <= DIV_RESET;
            blk_op  <= '0;
            blk_en  <= '0;
            illegal <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    ADR_OPC:    opcode <= reg_wdata;
                    ADR_TXN:    tx_cnt <= reg_wdata;
                    ADR_RXN:    rx_cnt <= reg_wdata;
                    ADR_DIV:    div    <= reg_wdata;
                    ADR_BLK_EN: blk_en <= reg_wdata[SLOTS-1:0];
                    default: begin
                        for (int i = 0; i < SLOTS; i++) begin
                            if (reg_addr == ADR_BLK0 + 8'(i)) blk_op[i] <= reg_wdata;
                        end
                    end
                endcase
            end
            // R9: sticky flag, write-one-to-clear, set wins
            if (illegal_set)
                illegal <= 1'b1;
            else if (reg_wr && (reg_addr == ADR_CTRL2) && reg_wdata[5])
                illegal <= 1'b0;
        end
    end

    // R6: engine writes take the buffer; bus writes fill it while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
        end else if (eng_wr_en) begin
            mem[eng_wr_idx] <= eng_wr_data;
        end else if (reg_wr && buf_hit) begin
            mem[bus_idx] <= reg_wdata;
        end
    end

    assign eng_rd_data = (eng_rd_idx < BUF_LENI) ? mem[eng_rd_idx] : 8'h00;

    always_comb begin
        reg_rdata = '0;
        if (buf_hit) begin
            reg_rdata = mem[bus_idx];
        end else begin
            case (reg_addr)
                ADR_CTRL2:  reg_rdata = {2'b00, illegal, 5'b00000};
                ADR_BLK_EN: reg_rdata = 8'(blk_en);
                ADR_DIV:    reg_rdata = div;
                ADR_OPC:    reg_rdata = opcode;
                ADR_TXN:    reg_rdata = tx_cnt;
                ADR_RXN:    reg_rdata = rx_cnt;
                ADR_STAT:   reg_rdata = {busy, 7'b0000000};
                default: begin
                    for (int i = 0; i < SLOTS; i++) begin
                        if (reg_addr == ADR_BLK0 + 8'(i)) reg_rdata = blk_op[i];
                    end
                end
            endcase
        end
    end

    // R10: a start seen while busy must not disturb the running frame
    trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> busy);

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
    import spi_cmd_pkg::*;
#(
    parameter int  BUF_BYTES = 71,
    localparam int BIDX_W    = $clog2(BUF_BYTES + 1),
    localparam int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [CNT_W-1:0]  tx_n,
    input  logic [CNT_W-1:0]  rx_n,
    input  logic [7:0]        div,
    input  logic              miso,
    output logic [BIDX_W-1:0] rd_idx,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [BIDX_W-1:0] wr_idx,
    output logic [7:0]        wr_data,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy
);

    localparam logic [BIDX_W-1:0] BUF_LENI = BIDX_W'(BUF_BYTES);

    eng_state_t       state, state_nx;
    logic [7:0]       hcnt;
    logic             tick;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] byte_idx;
    logic [CNT_W-1:0] tx_lat;
    logic [CNT_W-1:0] total_lat;
    logic [7:0]       sh_out;
    logic [6:0]       sh_in;
    logic             sck_q, cs_q, mosi_q;
    logic             rise_ev, fall_ev, last_fall;
    logic [7:0]       next_src;

    assign tick      = (hcnt == div);
    assign rise_ev   = tick && ((state == ST_SETUP) || ((state == ST_SHIFT) && !sck_q));
    assign fall_ev   = tick && (state == ST_SHIFT) && sck_q;
    assign last_fall = fall_ev && (bit_cnt == 3'd0) && (byte_idx == total_lat);
    assign rd_idx    = BIDX_W'(byte_idx - CNT_W'(1));
    assign next_src  = (byte_idx <= tx_lat) ? rd_data : 8'h00;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)     state_nx = ST_SETUP;
            ST_SETUP: if (tick)      state_nx = ST_SHIFT;
            ST_SHIFT: if (last_fall) state_nx = ST_HOLD;
            ST_HOLD:  if (tick)      state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt      <= '0;
            bit_cnt   <= '0;
            byte_idx  <= '0;
            tx_lat    <= '0;
            total_lat <= '0;
            sh_out    <= '0;
            sh_in     <= '0;
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
            mosi_q    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if ((state == ST_IDLE) || tick) hcnt <= '0;
            else                            hcnt <= hcnt + 8'd1;

            if ((state == ST_IDLE) && start) begin
                // R4: chip select falls with the opcode MSB already driven
                cs_q      <= 1'b0;
                mosi_q    <= opcode[7];
                sh_out    <= {opcode[6:0], 1'b0};
                bit_cnt   <= '0;
                byte_idx  <= '0;
                tx_lat    <= tx_n;
                total_lat <= CNT_W'(1) + tx_n + rx_n;
            end

            if (rise_ev) begin
                sck_q <= 1'b1;
                sh_in <= {sh_in[5:0], miso};
                if (bit_cnt == 3'd7) begin
                    bit_cnt  <= '0;
                    byte_idx <= byte_idx + CNT_W'(1);
                    // R6: reply bytes land right after the sent bytes
                    if (byte_idx > tx_lat) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= BIDX_W'(byte_idx - CNT_W'(1));
                        wr_data <= {sh_in, miso};
                    end
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                end
            end

            if (fall_ev) begin
                sck_q <= 1'b0;
                if (bit_cnt == 3'd0) begin
                    if (byte_idx == total_lat) begin
                        mosi_q <= 1'b0;
                    end else begin
                        // R5: buffered bytes, then zeros while receiving
                        mosi_q <= next_src[7];
                        sh_out <= {next_src[6:0], 1'b0};
                    end
                end else begin
                    mosi_q <= sh_out[7];
                    sh_out <= {sh_out[6:0], 1'b0};
                end
            end

            if ((state == ST_HOLD) && tick) begin
                cs_q   <= 1'b1;
                mosi_q <= 1'b0;
            end
        end
    end

    assign sck  = sck_q;
    assign cs_n = cs_q;
    assign mosi = mosi_q;
    assign busy = (state != ST_IDLE);

    // R4
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cs_q && !sck_q));

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi_q));

    // R6
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_idx < BUF_LENI) && !cs_q));

    // R4
    sck_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |-> !cs_q);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int         BUF_BYTES = 71,
    parameter int         SLOTS     = 4,
    parameter logic [7:0] DIV_RESET = 8'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    localparam int         BIDX_W = $clog2(BUF_BYTES + 1);
    localparam logic [7:0] BUF8   = 8'(BUF_BYTES);

    logic [7:0]            opcode, tx_cnt, rx_cnt, div;
    logic [SLOTS-1:0][7:0] blk_op;
    logic [SLOTS-1:0]      blk_en;
    logic                  illegal, trig, busy, blocked;
    logic                  start, illegal_set;
    logic [7:0]            tx_eff, rx_room, rx_eff;
    logic [BIDX_W-1:0]     eng_rd_idx, eng_wr_idx;
    logic [7:0]            eng_rd_data, eng_wr_data;
    logic                  eng_wr_en;

    // R7: clip counts so sent plus received bytes fit the buffer
    assign tx_eff  = (tx_cnt > BUF8) ? BUF8 : tx_cnt;
    assign rx_room = BUF8 - tx_eff;
    assign rx_eff  = (rx_cnt > rx_room) ? rx_room : rx_cnt;

    // R8, R10
    assign start       = trig && !busy && !blocked;
    assign illegal_set = trig && !busy && blocked;

    spi_cmd_regs #(
        .BUF_BYTES (BUF_BYTES),
        .SLOTS     (SLOTS),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy        (busy),
        .illegal_set (illegal_set),
        .eng_rd_idx  (eng_rd_idx),
        .eng_rd_data (eng_rd_data),
        .eng_wr_en   (eng_wr_en),
        .eng_wr_idx  (eng_wr_idx),
        .eng_wr_data (eng_wr_data),
        .opcode      (opcode),
        .tx_cnt      (tx_cnt),
        .rx_cnt      (rx_cnt),
        .div         (div),
        .blk_op      (blk_op),
        .blk_en      (blk_en),
        .illegal     (illegal),
        .trig        (trig)
    );

    spi_cmd_block #(
        .SLOTS (SLOTS)
    ) u_block (
        .opcode (opcode),
        .blk_op (blk_op),
        .blk_en (blk_en),
        .hit    (blocked)
    );

    spi_cmd_shift #(
        .BUF_BYTES (BUF_BYTES)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opcode  (opcode),
        .tx_n    (tx_eff),
        .rx_n    (rx_eff),
        .div     (div),
        .miso    (spi_miso),
        .rd_idx  (eng_rd_idx),
        .rd_data (eng_rd_data),
        .wr_en   (eng_wr_en),
        .wr_idx  (eng_wr_idx),
        .wr_data (eng_wr_data),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .busy    (busy)
    );

    // R8
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal) |-> (!busy && spi_cs_n));

endmodule

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h4F;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    // reference state kept from the requirements
    logic [7:0] m_opc = 0, m_tx = 0, m_rx = 0, m_div = 8'd1;
    logic [7:0] m_blk [4] = '{default: 8'h00};
    logic [3:0] m_en = 4'h0;
    logic [7:0] sh_buf [71] = '{default: 8'h00};
    int         rem = 0;
    bit         m_illegal = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input int i);
        return 8'(8'h5A ^ (i * 37));
    endfunction

    function automatic int eff_tx();
        return (m_tx > 71) ? 71 : int'(m_tx);
    endfunction

    function automatic int eff_rx();
        int room = 71 - eff_tx();
        return (m_rx > room) ? room : int'(m_rx);
    endfunction

    function automatic bit is_blocked();
        for (int i = 0; i < 4; i++)
            if (m_en[i] && m_blk[i] == m_opc) return 1'b1;
        return 1'b0;
    endfunction

    // cycle-level model of the frame length
    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0;
        end else if (reg_wr && reg_addr == 8'h47 && reg_wdata[7] && rem == 0) begin
            if (is_blocked()) m_illegal = 1'b1;
            else rem = (16 * (1 + eff_tx() + eff_rx()) + 1) * (int'(m_div) + 1);
        end else if (rem > 0) begin
            rem = rem - 1;
        end
    end

    // R4: compared every clock against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(spi_cs_n == (rem == 0), "R4", "cs_n vs model", spi_cs_n, rem == 0);
            chk(!(spi_cs_n && spi_sck), "R4", "sck low outside frame", spi_sck, 0);
        end
    end

    // device model on the serial side
    int         cs_falls = 0;
    int         in_bits = 0;
    int         out_cnt = 0;
    logic [7:0] cur_in = 0;
    logic [7:0] seen [$];

    always @(negedge spi_cs_n) begin
        logic [7:0] t;
        cs_falls++;
        in_bits = 0;
        out_cnt = 0;
        t = resp(0);
        spi_miso = t[7];
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            cur_in = {cur_in[6:0], spi_mosi};
            in_bits++;
            if (in_bits == 8) begin
                seen.push_back(cur_in);
                in_bits = 0;
            end
        end
    end

    always @(negedge spi_sck) begin
        logic [7:0] t;
        if (!spi_cs_n) begin
            out_cnt++;
            t = resp(out_cnt / 8);
            spi_miso = t[7 - (out_cnt % 8)];
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        case (a)
            8'h45: m_opc = d;
            8'h48: m_tx = d;
            8'h4B: m_rx = d;
            8'h09: m_div = d;
            8'h08: m_en = d[3:0];
            8'h04, 8'h05, 8'h06, 8'h07: m_blk[a - 8'h04] = d;
            8'h02: if (d[5]) m_illegal = 1'b0;
            default: if (a >= 8'h80 && a < 8'h80 + 71) sh_buf[a - 8'h80] = d;
        endcase
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        reg_addr = 8'h4F;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h4F;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (rem != 0 || !spi_cs_n);
    endtask

    task automatic load_buf(input int n, input int seed);
        for (int i = 0; i < n; i++) wr(8'(8'h80 + i), 8'(seed + i * 13));
    endtask

    task automatic run_xfer(input logic [7:0] opc, input logic [7:0] txn,
                            input logic [7:0] rxn, input logic [7:0] dv);
        logic [7:0] d;
        int tx, rx, falls0;
        wr(8'h09, dv);
        wr(8'h45, opc);
        wr(8'h48, txn);
        wr(8'h4B, rxn);
        tx = eff_tx();
        rx = eff_rx();
        seen.delete();
        falls0 = cs_falls;
        wr(8'h47, 8'h80);
        rd(8'h4F, d);
        chk(d[7] == 1'b1, "R3", "busy after start", d, 8'h80);
        wait_idle();
        rd(8'h4F, d);
        chk(d[7] == 1'b0, "R3", "busy after frame", d, 0);
        chk(cs_falls == falls0 + 1, "R3", "one frame", cs_falls - falls0, 1);
        // R7: clipped byte count on the wire
        chk(seen.size() == 1 + tx + rx, "R7", "bytes on MOSI", seen.size(), 1 + tx + rx);
        if (seen.size() == 1 + tx + rx) begin
            chk(seen[0] == opc, "R5", "opcode first", seen[0], opc);
            for (int i = 0; i < tx; i++)
                chk(seen[1 + i] == sh_buf[i], "R5", "sent byte", seen[1 + i], sh_buf[i]);
            for (int i = 0; i < rx; i++)
                chk(seen[1 + tx + i] == 8'h00, "R5", "fill during receive", seen[1 + tx + i], 0);
        end
        for (int i = 0; i < rx; i++) sh_buf[tx + i] = resp(1 + tx + i);
        for (int i = 0; i < 71; i++) begin
            rd(8'(8'h80 + i), d);
            chk(d == sh_buf[i], "R6", "buffer slot", d, sh_buf[i]);
        end
    endtask

    initial begin
        logic [7:0] d;
        int falls0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        chk(spi_cs_n == 1'b1, "R1", "cs_n reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1", "sck reset", spi_sck, 0);
        rd(8'h4F, d); chk(d == 8'h00, "R1", "status reset", d, 0);
        rd(8'h02, d); chk(d == 8'h00, "R1", "illegal reset", d, 0);
        rd(8'h09, d); chk(d == 8'h01, "R1", "divider reset", d, 1);

        // R2
        wr(8'h45, 8'h3C); rd(8'h45, d); chk(d == 8'h3C, "R2", "opcode reg", d, 8'h3C);
        wr(8'h48, 8'd80); rd(8'h48, d); chk(d == 8'd80, "R2", "send count reg", d, 80);
        wr(8'h4B, 8'd9);  rd(8'h4B, d); chk(d == 8'd9, "R2", "recv count reg", d, 9);
        wr(8'h05, 8'hA1); rd(8'h05, d); chk(d == 8'hA1, "R2", "block slot reg", d, 8'hA1);
        wr(8'h08, 8'h0B); rd(8'h08, d); chk(d == 8'h0B, "R2", "enable reg", d, 8'h0B);
        wr(8'hC6, 8'h77); rd(8'hC6, d); chk(d == 8'h77, "R2", "last buffer slot", d, 8'h77);
        wr(8'h08, 8'h00);

        load_buf(71, 3);
        run_xfer(8'h9F, 8'd0, 8'd3, 8'd1);
        run_xfer(8'h02, 8'd4, 8'd0, 8'd0);
        run_xfer(8'h0B, 8'd4, 8'd6, 8'd2);
        run_xfer(8'h05, 8'd0, 8'd0, 8'd0);
        load_buf(71, 91);
        run_xfer(8'h02, 8'd80, 8'd5, 8'd0);
        run_xfer(8'h03, 8'd60, 8'd20, 8'd0);

        // R8: enabled matching slot blocks the command
        wr(8'h06, 8'hC7);
        wr(8'h04, 8'h9F);
        wr(8'h08, 8'h05);
        wr(8'h45, 8'hC7);
        falls0 = cs_falls;
        wr(8'h47, 8'h80);
        repeat (40) @(negedge clk);
        chk(cs_falls == falls0, "R8", "no frame when blocked", cs_falls - falls0, 0);
        rd(8'h4F, d); chk(d == 8'h00, "R8", "busy stays 0", d, 0);
        rd(8'h02, d); chk(d == 8'h20, "R8", "illegal flag set", d, 8'h20);

        // R9
        wr(8'h02, 8'h00);
        rd(8'h02, d); chk(d == 8'h20, "R9", "flag sticky", d, 8'h20);
        wr(8'h02, 8'h20);
        rd(8'h02, d); chk(d == 8'h00, "R9", "flag cleared", d, 0);
        wr(8'h08, 8'h01);
        run_xfer(8'hC7, 8'd2, 8'd2, 8'd1);
        rd(8'h02, d); chk(d == 8'h00, "R9", "disabled slot passes", d, 0);

        // R10: second start during a frame
        wr(8'h09, 8'd1);
        wr(8'h45, 8'h0B);
        wr(8'h48, 8'd2);
        wr(8'h4B, 8'd2);
        falls0 = cs_falls;
        wr(8'h47, 8'h80);
        repeat (20) @(negedge clk);
        wr(8'h47, 8'h80);
        wait_idle();
        repeat (60) @(negedge clk);
        chk(cs_falls == falls0 + 1, "R10", "start while busy ignored",
            cs_falls - falls0, 1);
        rd(8'h4F, d); chk(d == 8'h00, "R10", "idle after frame", d, 0);

        finish_run();
    end

endmodule